// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the write cycles that a host drives onto a parallel flash bus and recognises the multi-write command sequences that control the array. It handles four kinds of sequence. The first is the standard four-write program. The second is the six-write whole-array erase. The third is a sub-mode, entered by a short unlock, in which each program takes only two writes. The fourth is a two-write exit from that sub-mode. A high-voltage flag on the acceleration pin puts the decoder straight into the shortened mode.

Recognised operations appear as requests. A program request carries the captured address and byte. An erase request carries no payload. Each request stays high until the array controller returns `done_i`, and writes that arrive in the meantime are dropped. A one-cycle pulse marks every return to plain read mode after an aborted or exited sequence. A two-bit mode output always shows whether the decoder is idle in read mode, part-way through a standard sequence, or in the shortened mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: On reset, mode_o is 0, and prog_req_o, erase_req_o and read_ret_o are low. Mode encoding: 0 means read, 1 means a standard sequence is in progress, 2 means bypass.
- R2: Writes of AAh at 555h, then 55h at 2AAh, then 20h at 555h move mode_o to 2 on the cycle after the third write. Only the low 12 address bits are compared, for every command address.
- R3: Writes of AAh at 555h, then 55h at 2AAh, then A0h at 555h, then any address and byte raise prog_req_o on the cycle after the fourth write. prog_addr_o and prog_data_o then equal that fourth write, and mode_o returns to 0 with no read_ret_o pulse.
- R4: In bypass, a write of A0h at any address followed by any address and byte raises prog_req_o with that address and byte. mode_o stays 2, and the pair can be repeated with no unlock writes.
- R5: In bypass, a write whose data is neither A0h nor 90h has no effect: mode_o stays 2, no request is raised and no pulse is given.
- R6: In bypass, a write of 90h followed by a write of 00h sets mode_o to 0 and pulses read_ret_o high for exactly one cycle. If the write after 90h is anything other than 00h, the decoder stays in bypass with no pulse.
- R7: While accel_i is high, mode_o is 2 from the next cycle on. A write in that cycle is dropped if the decoder was not already in bypass. A bypass exit attempted while accel_i is high leaves mode_o at 2.
- R8: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raise erase_req_o on the cycle after the sixth write, and mode_o returns to 0.
- R9: In a standard sequence, a wrong address or data at an unlock or command step (F0h included) returns mode_o to 0 and pulses read_ret_o for one cycle. In read mode, a write that does not start an unlock has no effect and gives no pulse.
- R10: A request stays high until done_i is sampled high, and drops on the next cycle. While a request is high, writes are ignored, the captured address and data do not change, and the two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | ADDR_W | Write address |
| data_i | input | 8 | Write data |
| accel_i | input | 1 | High voltage present on the acceleration pin |
| done_i | input | 1 | Array controller finished the pending request |
| mode_o | output | 2 | 0 read, 1 standard sequence, 2 bypass |
| prog_req_o | output | 1 | Program request, held until done |
| prog_addr_o | output | ADDR_W | Address to program |
| prog_data_o | output | 8 | Byte to program |
| erase_req_o | output | 1 | Whole-array erase request, held until done |
| read_ret_o | output | 1 | One-cycle pulse on return to read mode |

## Verification
Directed sequences exercise each command in full. Each is then broken at every step with a wrong address or a wrong byte, which separates correct aborts from sequences that are accepted too loosely. Upper address bits are set during unlock writes, which shows that only the low bits are decoded. Writes made while a request is pending, and bypass exits made with the acceleration flag high, tell dropped writes apart from accepted ones. A long random run then draws its writes from a pool biased toward the command bytes and addresses, with random done and acceleration activity, and compares every cycle against a reference model so that unusual interleavings show up.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_UL1, ST_UL2, ST_PGM, ST_ESET, ST_EUL1, ST_EUL2,
    ST_BYP, ST_BPGM, ST_BRST
  } seq_state_e;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_SEQ  = 2'd1,
    MODE_BYP  = 2'd2
  } mode_e;

  localparam logic [7:0] D_KEY1    = 8'hAA;
  localparam logic [7:0] D_KEY2    = 8'h55;
  localparam logic [7:0] C_PROG    = 8'hA0;
  localparam logic [7:0] C_ESETUP  = 8'h80;
  localparam logic [7:0] C_CHIP    = 8'h10;
  localparam logic [7:0] C_BYP_IN  = 8'h20;
  localparam logic [7:0] C_BYP_X1  = 8'h90;
  localparam logic [7:0] C_BYP_X2  = 8'h00;
endpackage

// File: rtl/flash_cyc_match.sv
module flash_cyc_match #(
  parameter int          MATCH_W  = 12,
  parameter logic [11:0] CMD_ADDR = 12'h555,
  parameter logic [11:0] ALT_ADDR = 12'h2AA
) (
  input  logic [MATCH_W-1:0] addr_lo_i,
  input  logic [7:0]         data_i,
  output logic               at_cmd_o,
  output logic               key1_o,
  output logic               key2_o
);
  import flash_cmd_pkg::*;

  logic at_alt;

  assign at_cmd_o = (addr_lo_i == MATCH_W'(CMD_ADDR));
  assign at_alt   = (addr_lo_i == MATCH_W'(ALT_ADDR));
  assign key1_o   = at_cmd_o && (data_i == D_KEY1);
  assign key2_o   = at_alt   && (data_i == D_KEY2);
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_ok_i,
  input  logic       accel_i,
  input  logic       at_cmd_i,
  input  logic       key1_i,
  input  logic       key2_i,
  input  logic [7:0] data_i,
  output logic [1:0] mode_o,
  output logic       issue_prog_o,
  output logic       issue_erase_o,
  output logic       read_ret_o
);
  import flash_cmd_pkg::*;

  seq_state_e st_q, st_d;
  logic       ret_d, ret_q;
  logic       in_byp;

  assign in_byp = (st_q == ST_BYP) || (st_q == ST_BPGM) || (st_q == ST_BRST);

  always_comb begin
    st_d          = st_q;
    ret_d         = 1'b0;
    issue_prog_o  = 1'b0;
    issue_erase_o = 1'b0;
    if (accel_i && !in_byp) begin
      st_d = ST_BYP;
    end else if (wr_ok_i) begin
      unique case (st_q)
        ST_READ: if (key1_i) st_d = ST_UL1;
        ST_UL1: begin
          if (key2_i) st_d = ST_UL2;
          else begin st_d = ST_READ; ret_d = 1'b1; end
        end
        ST_UL2: begin
          if (at_cmd_i && data_i == C_PROG)        st_d = ST_PGM;
          else if (at_cmd_i && data_i == C_ESETUP) st_d = ST_ESET;
          else if (at_cmd_i && data_i == C_BYP_IN) st_d = ST_BYP;
          else begin st_d = ST_READ; ret_d = 1'b1; end
        end
        ST_PGM: begin
          issue_prog_o = 1'b1;
          st_d         = ST_READ;
        end
        ST_ESET: begin
          if (key1_i) st_d = ST_EUL1;
          else begin st_d = ST_READ; ret_d = 1'b1; end
        end
        ST_EUL1: begin
          if (key2_i) st_d = ST_EUL2;
          else begin st_d = ST_READ; ret_d = 1'b1; end
        end
        ST_EUL2: begin
          if (at_cmd_i && data_i == C_CHIP) begin
            issue_erase_o = 1'b1;
            st_d          = ST_READ;
          end else begin
            st_d  = ST_READ;
            ret_d = 1'b1;
          end
        end
        ST_BYP: begin
          if (data_i == C_PROG)        st_d = ST_BPGM;
          else if (data_i == C_BYP_X1) st_d = ST_BRST;
        end
        ST_BPGM: begin
          issue_prog_o = 1'b1;
          st_d         = ST_BYP;
        end
        ST_BRST: begin
          // exit blocked while the high voltage holds the mode
          if (data_i == C_BYP_X2 && !accel_i) begin
            st_d  = ST_READ;
            ret_d = 1'b1;
          end else begin
            st_d = ST_BYP;
          end
        end
        default: st_d = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_READ;
      ret_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ret_q <= ret_d;
    end
  end

  always_comb begin
    if (st_q == ST_READ) mode_o = MODE_READ;
    else if (in_byp)     mode_o = MODE_BYP;
    else                 mode_o = MODE_SEQ;
  end

  assign read_ret_o = ret_q;
endmodule

// File: rtl/flash_req_slot.sv
module flash_req_slot #(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_prog_i,
  input  logic              issue_erase_i,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              prog_req_o,
  output logic              erase_req_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [7:0]        prog_data_o,
  output logic              busy_o
);
  logic              prog_q, erase_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;

  assign busy_o = prog_q | erase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q  <= 1'b0;
      erase_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (busy_o) begin
      if (done_i) begin
        prog_q  <= 1'b0;
        erase_q <= 1'b0;
      end
    end else begin
      if (issue_prog_i) begin
        prog_q <= 1'b1;
        addr_q <= addr_i;
        data_q <= data_i;
      end
      if (issue_erase_i) erase_q <= 1'b1;
    end
  end

  assign prog_req_o  = prog_q;
  assign erase_req_o = erase_q;
  assign prog_addr_o = addr_q;
  assign prog_data_o = data_q;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int          ADDR_W   = 24,
  parameter int          MATCH_W  = 12,
  parameter logic [11:0] CMD_ADDR = 12'h555,
  parameter logic [11:0] ALT_ADDR = 12'h2AA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              accel_i,
  input  logic              done_i,
  output logic [1:0]        mode_o,
  output logic              prog_req_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [7:0]        prog_data_o,
  output logic              erase_req_o,
  output logic              read_ret_o
);
  localparam int CW = (MATCH_W < ADDR_W) ? MATCH_W : ADDR_W;

  logic busy, wr_ok, at_cmd, key1, key2, issue_prog, issue_erase;

  assign wr_ok = wr_i & ~busy;

  flash_cyc_match #(
    .MATCH_W (CW),
    .CMD_ADDR(CMD_ADDR),
    .ALT_ADDR(ALT_ADDR)
  ) u_match (
    .addr_lo_i(addr_i[CW-1:0]),
    .data_i   (data_i),
    .at_cmd_o (at_cmd),
    .key1_o   (key1),
    .key2_o   (key2)
  );

  flash_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_ok_i      (wr_ok),
    .accel_i      (accel_i),
    .at_cmd_i     (at_cmd),
    .key1_i       (key1),
    .key2_i       (key2),
    .data_i       (data_i),
    .mode_o       (mode_o),
    .issue_prog_o (issue_prog),
    .issue_erase_o(issue_erase),
    .read_ret_o   (read_ret_o)
  );

  flash_req_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_prog_i (issue_prog),
    .issue_erase_i(issue_erase),
    .done_i       (done_i),
    .addr_i       (addr_i),
    .data_i       (data_i),
    .prog_req_o   (prog_req_o),
    .erase_req_o  (erase_req_o),
    .prog_addr_o  (prog_addr_o),
    .prog_data_o  (prog_data_o),
    .busy_o       (busy)
  );
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              accel_i,
  input logic              done_i,
  input logic [1:0]        mode_o,
  input logic              prog_req_o,
  input logic [ADDR_W-1:0] prog_addr_o,
  input logic [7:0]        prog_data_o,
  input logic              erase_req_o,
  input logic              read_ret_o
);
  a_r10_prog_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_o && !done_i) |=> prog_req_o);
  a_r10_erase_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_req_o && !done_i) |=> erase_req_o);
  a_r10_prog_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_o && done_i) |=> !prog_req_o);
  a_r10_payload_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_o && !done_i) |=> ($stable(prog_addr_o) && $stable(prog_data_o)));
  a_r10_one_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_req_o && erase_req_o));
  a_r7_accel_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accel_i |=> (mode_o == 2'd2));
  a_r9_ret_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_ret_o |-> (mode_o == 2'd0));
  a_r9_ret_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_ret_o |=> !read_ret_o);
  a_r8_erase_from_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(erase_req_o) |-> ($past(mode_o) == 2'd1 && mode_o == 2'd0));
  a_r4_byp_prog_keeps_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(prog_req_o) && $past(mode_o) == 2'd2) |-> (mode_o == 2'd2));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .accel_i    (accel_i),
  .done_i     (done_i),
  .mode_o     (mode_o),
  .prog_req_o (prog_req_o),
  .prog_addr_o(prog_addr_o),
  .prog_data_o(prog_data_o),
  .erase_req_o(erase_req_o),
  .read_ret_o (read_ret_o)
);

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        accel_i = 1'b0;
  logic        done_i = 1'b0;
  logic [1:0]  mode_o;
  logic        prog_req_o, erase_req_o, read_ret_o;
  logic [23:0] prog_addr_o;
  logic [7:0]  prog_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model: 0 rd,1 ul1,2 ul2,3 pgm,4 eset,5 eul1,6 eul2,7 byp,8 bpgm,9 brst
  int          m_st = 0;
  bit          m_preq = 0, m_ereq = 0, m_ret = 0;
  logic [23:0] m_paddr = '0;
  logic [7:0]  m_pdata = '0;
  bit          acc_hold = 0;

  always #10 clk_i = ~clk_i;

  flash_cmd_decoder dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .data_i(data_i),
    .accel_i(accel_i), .done_i(done_i), .mode_o(mode_o), .prog_req_o(prog_req_o),
    .prog_addr_o(prog_addr_o), .prog_data_o(prog_data_o), .erase_req_o(erase_req_o),
    .read_ret_o(read_ret_o)
  );

  function automatic int exp_mode(int st);
    if (st == 0) return 0;
    if (st >= 7) return 2;
    return 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic step(input bit w, input logic [23:0] a, input logic [7:0] d,
                      input bit acc, input bit dn, input string tag);
    bit busy, ip, ie, ul1, ul2, atc, nret, ok;
    int nst;
    atc  = (a[11:0] == 12'h555);
    ul1  = atc && d == 8'hAA;
    ul2  = (a[11:0] == 12'h2AA) && d == 8'h55;
    busy = m_preq || m_ereq;
    ip = 0; ie = 0; nret = 0; nst = m_st;
    if (acc && m_st < 7) nst = 7;
    else if (w && !busy) begin
      case (m_st)
        0: if (ul1) nst = 1;
        1: if (ul2) nst = 2; else begin nst = 0; nret = 1; end
        2: if (atc && d == 8'hA0) nst = 3;
           else if (atc && d == 8'h80) nst = 4;
           else if (atc && d == 8'h20) nst = 7;
           else begin nst = 0; nret = 1; end
        3: begin ip = 1; nst = 0; end
        4: if (ul1) nst = 5; else begin nst = 0; nret = 1; end
        5: if (ul2) nst = 6; else begin nst = 0; nret = 1; end
        6: if (atc && d == 8'h10) begin ie = 1; nst = 0; end
           else begin nst = 0; nret = 1; end
        7: if (d == 8'hA0) nst = 8; else if (d == 8'h90) nst = 9;
        8: begin ip = 1; nst = 7; end
        9: if (d == 8'h00 && !acc) begin nst = 0; nret = 1; end else nst = 7;
        default: nst = 0;
      endcase
    end
    if (busy && dn) begin m_preq = 0; m_ereq = 0; end
    if (ip) begin m_preq = 1; m_paddr = a; m_pdata = d; end
    if (ie) m_ereq = 1;
    m_st = nst;
    m_ret = nret;
    wr_i = w; addr_i = a; data_i = d; accel_i = acc; done_i = dn;
    @(negedge clk_i);
    wr_i = 0; done_i = 0;
    ok = (int'(mode_o) == exp_mode(m_st)) && prog_req_o == m_preq && erase_req_o == m_ereq
         && read_ret_o == m_ret && (!m_preq || (prog_addr_o == m_paddr && prog_data_o == m_pdata));
    chk(ok, tag,
        $sformatf("mode=%0d p=%b e=%b r=%b a=%h d=%h", mode_o, prog_req_o, erase_req_o,
                  read_ret_o, prog_addr_o, prog_data_o),
        $sformatf("mode=%0d p=%b e=%b r=%b a=%h d=%h", exp_mode(m_st), m_preq, m_ereq,
                  m_ret, m_paddr, m_pdata));
  endtask

  task automatic wr(input logic [23:0] a, input logic [7:0] d, input string tag);
    step(1, a, d, acc_hold, 0, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 24'h0, 8'h0, acc_hold, 0, tag);
  endtask
  task automatic done(input string tag);
    step(0, 24'h0, 8'h0, acc_hold, 1, tag);
  endtask
  task automatic unlock(input string tag);
    wr(24'h000555, 8'hAA, tag);
    wr(24'h0002AA, 8'h55, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] pool [10];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(mode_o == 2'd0 && !prog_req_o && !erase_req_o && !read_ret_o, "R1",
        $sformatf("mode=%0d p=%b e=%b r=%b", mode_o, prog_req_o, erase_req_o, read_ret_o),
        "mode=0 p=0 e=0 r=0");
    // R9 stray writes in read mode
    wr(24'h001234, 8'h55, "R9 stray");
    wr(24'h000555, 8'hF0, "R9 stray F0");
    // R3 standard program
    unlock("R3");
    wr(24'h000555, 8'hA0, "R3 cmd");
    wr(24'h123456, 8'h5A, "R3 data");
    chk(prog_req_o && prog_addr_o == 24'h123456 && prog_data_o == 8'h5A && mode_o == 2'd0,
        "R3 request", $sformatf("p=%b a=%h d=%h m=%0d", prog_req_o, prog_addr_o, prog_data_o, mode_o),
        "p=1 a=123456 d=5a m=0");
    // R10 writes while busy are ignored
    wr(24'h000555, 8'hAA, "R10 busy write");
    wr(24'h000777, 8'h11, "R10 busy write");
    chk(mode_o == 2'd0 && prog_addr_o == 24'h123456, "R10 ignored",
        $sformatf("m=%0d a=%h", mode_o, prog_addr_o), "m=0 a=123456");
    done("R10 done");
    chk(!prog_req_o, "R10 release", $sformatf("p=%b", prog_req_o), "p=0");
    // R9 aborts at each step
    wr(24'h000555, 8'hAA, "R9");
    wr(24'h0002AB, 8'h55, "R9 bad addr");
    chk(read_ret_o && mode_o == 2'd0, "R9 abort pulse",
        $sformatf("r=%b m=%0d", read_ret_o, mode_o), "r=1 m=0");
    idle("R9 pulse ends");
    unlock("R9"); wr(24'h000555, 8'hF0, "R9 F0 abort");
    unlock("R9"); wr(24'h000554, 8'hA0, "R9 cmd bad addr");
    unlock("R9"); wr(24'h000555, 8'h80, "R9"); wr(24'h000555, 8'hAB, "R9 eset bad");
    unlock("R9"); wr(24'h000555, 8'h80, "R9"); unlock("R9"); wr(24'h000555, 8'h30, "R9 erase bad");
    // R8 chip erase
    unlock("R8"); wr(24'h000555, 8'h80, "R8"); unlock("R8");
    wr(24'h000555, 8'h10, "R8 last");
    chk(erase_req_o && mode_o == 2'd0, "R8 erase req",
        $sformatf("e=%b m=%0d", erase_req_o, mode_o), "e=1 m=0");
    idle("R10 erase held");
    done("R10 erase done");
    // R2 bypass entry, upper address bits set
    wr(24'hABC555, 8'hAA, "R2"); wr(24'h7002AA, 8'h55, "R2");
    wr(24'hFFF555, 8'h20, "R2 enter");
    chk(mode_o == 2'd2, "R2 bypass", $sformatf("m=%0d", mode_o), "m=2");
    // R4 bypass program, twice
    for (int i = 0; i < 2; i++) begin
      wr(24'h000001, 8'hA0, "R4 cmd");
      wr(24'h00A000 + 24'(i), 8'hC3 ^ 8'(i), "R4 data");
      chk(prog_req_o && prog_addr_o == 24'h00A000 + 24'(i) && mode_o == 2'd2, "R4 request",
          $sformatf("p=%b a=%h m=%0d", prog_req_o, prog_addr_o, mode_o), "p=1 m=2");
      done("R4 done");
    end
    // R5 other commands ignored
    wr(24'h000555, 8'h80, "R5");
    wr(24'h000555, 8'hF0, "R5");
    wr(24'h000555, 8'hAA, "R5");
    chk(mode_o == 2'd2 && !prog_req_o && !read_ret_o, "R5 ignored",
        $sformatf("m=%0d p=%b r=%b", mode_o, prog_req_o, read_ret_o), "m=2 p=0 r=0");
    // R6 bypass exit
    wr(24'h0, 8'h90, "R6"); wr(24'h0, 8'h33, "R6 not exit");
    chk(mode_o == 2'd2 && !read_ret_o, "R6 stay", $sformatf("m=%0d", mode_o), "m=2");
    wr(24'h0, 8'h90, "R6"); wr(24'h0, 8'h00, "R6 exit");
    chk(mode_o == 2'd0 && read_ret_o, "R6 exit", $sformatf("m=%0d r=%b", mode_o, read_ret_o), "m=0 r=1");
    idle("R6 pulse ends");
    // R7 acceleration
    acc_hold = 1;
    wr(24'h000555, 8'hAA, "R7 write dropped");
    chk(mode_o == 2'd2, "R7 forced", $sformatf("m=%0d", mode_o), "m=2");
    wr(24'h0, 8'h90, "R7"); wr(24'h0, 8'h00, "R7 exit blocked");
    chk(mode_o == 2'd2 && !read_ret_o, "R7 blocked", $sformatf("m=%0d", mode_o), "m=2");
    wr(24'h0, 8'hA0, "R7"); wr(24'h000042, 8'h99, "R7 accel prog"); done("R7");
    acc_hold = 0;
    wr(24'h0, 8'h90, "R7"); wr(24'h0, 8'h00, "R7 exit after drop");
    idle("R7");
    // random mix
    pool = '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'h10, 8'h20, 8'h90, 8'h00, 8'hF0, 8'h3C};
    for (int i = 0; i < 4000; i++) begin
      logic [7:0]  d;
      logic [23:0] a;
      int k;
      k = $urandom_range(0, 9);
      d = (k == 9) ? 8'($urandom) : pool[k];
      case ($urandom_range(0, 5))
        0, 1, 2: a = {12'($urandom), (d == 8'h55) ? 12'h2AA : 12'h555};
        3:       a = {12'($urandom), 12'h2AA};
        default: a = 24'($urandom);
      endcase
      if ($urandom_range(0, 40) == 0) acc_hold = ~acc_hold;
      step($urandom_range(0, 2) != 0, a, d, acc_hold, $urandom_range(0, 3) == 0, "R9 random mix");
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule